// File: doc/BRIEF.md
# Extended control and status flag register

This block is an 8-bit control and status register that sits beside a real-time clock. It collects three sticky event flags: a RAM-clear request taken from an external pin, a wake-up alarm event and a kickstart event. It also holds one bit that controls a power-request pin, two spare storage bits and two read-only status bits. The read-only bits report whether the auxiliary battery is present and whether an update cycle is about to run or is running.

A host writes the whole byte in one cycle. Flag bits written with 1 are set, which lets software raise an interrupt condition on purpose. Flag bits written with 0 are cleared. Hardware events only ever set a flag. The companion enable bits come in as inputs. When a wake or kickstart flag is pending and its enable is on, the power bit is pulled back to its active state, so that the system is asked to power up. A lead-time counter runs on a 32.768 kHz tick enable. It raises the increment-in-progress bit ahead of each update and signals when the update itself may start.

Top module: `ecf_top`

## Requirements
- R1: After reset, rd_data_o reads 0x08 with aux_bat_i=0, or 0x88 with aux_bat_i=1: all flags and spare bits are 0, the power bit (bit 3) is 1, and pwr_act_o is 0.
- R2: Bit 7 of rd_data_o follows aux_bat_i directly. Bit 6 is the increment-in-progress status. Host writes to bits 7 and 6 have no effect.
- R3: The RAM-clear flag (bit 2) is set when the synchronized clr_pin_i falls while clr_en_i is 1. With the default two-stage synchronizer it reads 1 three clock edges after the pin goes low. It is not set when clr_en_i is 0.
- R4: A host write loads bit 2 from wr_data_i: 1 sets the RAM-clear flag and 0 clears it.
- R5: The wake flag (bit 1) is set in the cycle after wake_evt_i is 1. A host write loads it from wr_data_i[1]. Otherwise it holds its value.
- R6: The kickstart flag (bit 0) is set in the cycle after kick_evt_i is 1. A host write loads it from wr_data_i[0].
- R7: When a hardware set and a host write of 0 reach the same flag in the same cycle, the flag ends up at 1.
- R8: The power bit (bit 3) is loaded by host writes. pwr_act_o is the inverse of this bit: 1 means drive the pin low, 0 means high impedance.
- R9: One cycle after (wake flag AND wake_ie_i) OR (kickstart flag AND kick_en_i) holds, the power bit is 0. This overrides a host write of 1 made in the same cycle.
- R10: A pulse on upd_pend_i sets bit 6 on the next edge. upd_go_o pulses for one cycle after the LEAD_TICKS-th tick_i. Bit 6 clears on the edge after upd_done_i, but only once the lead count has finished.
- R11: The spare bits 5:4 store whatever is written to them and change neither the flags nor pwr_act_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Host write strobe, one cycle per write |
| wr_data_i | input | 8 | Host write data |
| rd_data_o | output | 8 | Register read value |
| clr_pin_i | input | 1 | Asynchronous RAM-clear request pin, falling edge active |
| clr_en_i | input | 1 | Enable for the RAM-clear flag |
| wake_evt_i | input | 1 | Wake-up alarm event, one-cycle pulse |
| kick_evt_i | input | 1 | Kickstart event, one-cycle pulse |
| wake_ie_i | input | 1 | Wake interrupt enable |
| kick_en_i | input | 1 | Kickstart enable |
| aux_bat_i | input | 1 | Auxiliary battery present |
| tick_i | input | 1 | 32.768 kHz tick enable, one cycle wide |
| upd_pend_i | input | 1 | Update scheduled, starts the lead count |
| upd_done_i | input | 1 | Update cycle finished |
| upd_go_o | output | 1 | Update may start, one-cycle pulse |
| pwr_act_o | output | 1 | 1 drives the power pin low, 0 leaves it high impedance |

## Verification
The collision that matters most is a hardware set meeting a host write of 0 on the same flag in the same cycle. The bench lines this up for the RAM-clear flag by counting the synchronizer edges after the pin falls, and for the wake and kickstart flags by pulsing the event together with the write strobe. Each flag must read 1 afterwards. A second collision is a host write of 1 to the power bit while an enabled wake flag is pending: the bit must stay 0 and pwr_act_o must stay 1.

// File: rtl/ecf_pkg.sv
package ecf_pkg;
  localparam int BIT_KF   = 0;
  localparam int BIT_WF   = 1;
  localparam int BIT_RF   = 2;
  localparam int BIT_PAB  = 3;
  localparam int BIT_INCR = 6;
  localparam int BIT_BAT  = 7;

  typedef struct packed {
    logic [1:0] spare;
    logic       pab;
    logic       rf;
    logic       wf;
    logic       kf;
  } ctl_t;

  localparam ctl_t CTL_RST = '{spare: 2'b00, pab: 1'b1, rf: 1'b0, wf: 1'b0, kf: 1'b0};
endpackage

// File: rtl/ecf_fall_det.sv
module ecf_fall_det #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  // idle-high reset so that no false edge appears after reset
  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_sync
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q[g] <= 1'b1;
        else         sync_q[g] <= (g == 0) ? pin_i : sync_q[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b1;
    else         prev_q <= sync_q[STAGES-1];
  end

  assign fall_o = prev_q & ~sync_q[STAGES-1];

  AST_FALL_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !fall_o); // R3
endmodule

// File: rtl/ecf_incr_tmr.sv
module ecf_incr_tmr #(
  parameter int LEAD_TICKS = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic pend_i,
  input  logic done_i,
  output logic incr_o,
  output logic go_o
);
  localparam int CNT_W = $clog2(LEAD_TICKS + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      incr_o <= 1'b0;
      go_o   <= 1'b0;
    end else begin
      go_o <= 1'b0;
      if (!incr_o && pend_i) begin
        incr_o <= 1'b1;
        busy_q <= 1'b1;
        cnt_q  <= CNT_W'(LEAD_TICKS);
      end else if (busy_q && tick_i) begin
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CNT_W'(1)) begin
          busy_q <= 1'b0;
          go_o   <= 1'b1;
        end
      end else if (incr_o && !busy_q && done_i) begin
        incr_o <= 1'b0;
      end
    end
  end

  AST_GO_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_o |=> !go_o); // R10
  AST_GO_IN_INCR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_o |-> incr_o); // R10
  AST_DONE_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && incr_o && !busy_q) |=> !incr_o); // R10
  AST_PEND_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_i && !incr_o) |=> incr_o); // R10
endmodule

// File: rtl/ecf_flag_reg.sv
module ecf_flag_reg
  import ecf_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic [7:0] wr_data_i,
  input  logic       rf_set_i,
  input  logic       wf_set_i,
  input  logic       kf_set_i,
  input  logic       wake_ie_i,
  input  logic       kick_en_i,
  output ctl_t       ctl_o
);
  ctl_t ctl_q, ctl_d;
  logic pab_force;

  assign pab_force = (ctl_q.wf & wake_ie_i) | (ctl_q.kf & kick_en_i);

  always_comb begin
    ctl_d = ctl_q;
    if (wr_en_i) begin
      ctl_d.spare = wr_data_i[5:4];
      ctl_d.pab   = wr_data_i[BIT_PAB];
      ctl_d.rf    = wr_data_i[BIT_RF];
      ctl_d.wf    = wr_data_i[BIT_WF];
      ctl_d.kf    = wr_data_i[BIT_KF];
    end
    // hardware sets win over a host clear
    ctl_d.rf = ctl_d.rf | rf_set_i;
    ctl_d.wf = ctl_d.wf | wf_set_i;
    ctl_d.kf = ctl_d.kf | kf_set_i;
    if (pab_force) ctl_d.pab = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctl_q <= CTL_RST;
    else         ctl_q <= ctl_d;
  end

  assign ctl_o = ctl_q;

  AST_RF_HW_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_set_i |=> ctl_q.rf); // R3
  AST_WF_HW_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wf_set_i |=> ctl_q.wf); // R5
  AST_KF_HW_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kf_set_i |=> ctl_q.kf); // R6
  AST_WF_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_i && !wf_set_i) |=> ctl_q.wf == $past(ctl_q.wf)); // R5
  AST_PAB_FORCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((ctl_q.wf && wake_ie_i) || (ctl_q.kf && kick_en_i)) |=> !ctl_q.pab); // R9
  AST_PAB_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !pab_force) |=> ctl_q.pab == $past(wr_data_i[BIT_PAB])); // R8
endmodule

// File: rtl/ecf_top.sv
module ecf_top
  import ecf_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int LEAD_TICKS  = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic [7:0] wr_data_i,
  output logic [7:0] rd_data_o,
  input  logic       clr_pin_i,
  input  logic       clr_en_i,
  input  logic       wake_evt_i,
  input  logic       kick_evt_i,
  input  logic       wake_ie_i,
  input  logic       kick_en_i,
  input  logic       aux_bat_i,
  input  logic       tick_i,
  input  logic       upd_pend_i,
  input  logic       upd_done_i,
  output logic       upd_go_o,
  output logic       pwr_act_o
);
  logic clr_fall;
  logic incr;
  ctl_t ctl;

  ecf_fall_det #(.STAGES(SYNC_STAGES)) i_fall (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (clr_pin_i),
    .fall_o (clr_fall)
  );

  ecf_incr_tmr #(.LEAD_TICKS(LEAD_TICKS)) i_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .pend_i (upd_pend_i),
    .done_i (upd_done_i),
    .incr_o (incr),
    .go_o   (upd_go_o)
  );

  ecf_flag_reg i_flags (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .rf_set_i  (clr_fall & clr_en_i),
    .wf_set_i  (wake_evt_i),
    .kf_set_i  (kick_evt_i),
    .wake_ie_i (wake_ie_i),
    .kick_en_i (kick_en_i),
    .ctl_o     (ctl)
  );

  always_comb begin
    rd_data_o           = {2'b00, ctl};
    rd_data_o[BIT_BAT]  = aux_bat_i;
    rd_data_o[BIT_INCR] = incr;
  end

  assign pwr_act_o = ~ctl.pab;

  AST_PWR_POLARITY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_act_o != rd_data_o[BIT_PAB]); // R8
endmodule

// File: tb/test_ecf_top.sv
module test_ecf_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       clr_pin = 1'b1, clr_en = 1'b0;
  logic       wake_evt = 1'b0, kick_evt = 1'b0;
  logic       wake_ie = 1'b0, kick_en = 1'b0;
  logic       aux_bat = 1'b1, tick = 1'b0;
  logic       upd_pend = 1'b0, upd_done = 1'b0;
  logic       upd_go, pwr_act;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  ecf_top i_ecf_top (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_data_o(rd_data), .clr_pin_i(clr_pin), .clr_en_i(clr_en),
    .wake_evt_i(wake_evt), .kick_evt_i(kick_evt), .wake_ie_i(wake_ie),
    .kick_en_i(kick_en), .aux_bat_i(aux_bat), .tick_i(tick),
    .upd_pend_i(upd_pend), .upd_done_i(upd_done), .upd_go_o(upd_go),
    .pwr_act_o(pwr_act)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic host_wr(input logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic one_tick();
    tick = 1'b1;
    @(posedge clk); @(negedge clk);
    tick = 1'b0;
  endtask

  initial begin
    #(8 * 100000);
    if (!finished) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1 reset value
    check(rd_data == 8'h88, "R1", rd_data, 8'h88);
    check(pwr_act == 1'b0, "R1", pwr_act, 0);
    aux_bat = 1'b0; #1;
    check(rd_data == 8'h08, "R1", rd_data, 8'h08);

    // R2 read-only top bits
    host_wr(8'hC8);
    check(rd_data == 8'h08, "R2", rd_data, 8'h08);
    aux_bat = 1'b1; #1;
    check(rd_data[7] == 1'b1, "R2", rd_data[7], 1);

    // exhaustive write sweep, no enables: R2 R4 R5 R6 R8 R11
    for (int d = 0; d < 256; d++) begin
      host_wr(8'(d));
      check(rd_data == {1'b1, 1'b0, 6'(d)}, "R4_R5_R6_R11", rd_data, {1'b1, 1'b0, 6'(d)});
      check(pwr_act == !d[3], "R8", pwr_act, !d[3]);
    end

    // R3 ram-clear edge with enable, latency 3 edges
    host_wr(8'h08);
    clr_en = 1'b1;
    clr_pin = 1'b0;
    idle(2);
    check(rd_data[2] == 1'b0, "R3", rd_data[2], 0);
    idle(1);
    check(rd_data[2] == 1'b1, "R3", rd_data[2], 1);
    clr_pin = 1'b1;
    idle(4);
    host_wr(8'h08);
    check(rd_data[2] == 1'b0, "R4", rd_data[2], 0);
    // R3 disabled
    clr_en = 1'b0;
    clr_pin = 1'b0;
    idle(6);
    check(rd_data[2] == 1'b0, "R3", rd_data[2], 0);
    clr_pin = 1'b1;
    idle(4);

    // R7 ram-clear edge meets host clear
    clr_en = 1'b1;
    host_wr(8'h0C);
    clr_pin = 1'b0;
    idle(2);
    host_wr(8'h08);
    check(rd_data[2] == 1'b1, "R7", rd_data[2], 1);
    clr_pin = 1'b1;
    clr_en = 1'b0;
    idle(4);

    // R7 wake and kick events meet host clear
    host_wr(8'h0B);
    wake_evt = 1'b1;
    host_wr(8'h08);
    wake_evt = 1'b0;
    check(rd_data[1:0] == 2'b10, "R7", rd_data[1:0], 2'b10);
    host_wr(8'h0B);
    kick_evt = 1'b1;
    host_wr(8'h08);
    kick_evt = 1'b0;
    check(rd_data[1:0] == 2'b01, "R7", rd_data[1:0], 2'b01);

    // R5 R6 plain events
    host_wr(8'h08);
    wake_evt = 1'b1; idle(1); wake_evt = 1'b0;
    check(rd_data[1] == 1'b1, "R5", rd_data[1], 1);
    idle(3);
    check(rd_data[1] == 1'b1, "R5", rd_data[1], 1);
    kick_evt = 1'b1; idle(1); kick_evt = 1'b0;
    check(rd_data[0] == 1'b1, "R6", rd_data[0], 1);

    // R9 force sweep over flags and enables
    for (int c = 0; c < 16; c++) begin
      wake_ie = 1'b0; kick_en = 1'b0;
      host_wr(8'h08);
      wake_ie = c[2]; kick_en = c[3];
      host_wr({4'h0, 1'b1, 1'b0, c[0], c[1]});
      idle(1);
      check(pwr_act == ((c[0] & c[2]) | (c[1] & c[3])), "R9", pwr_act,
            (c[0] & c[2]) | (c[1] & c[3]));
    end
    // R9 override of a host write of 1
    wake_ie = 1'b1; kick_en = 1'b0;
    host_wr(8'h0A);
    host_wr(8'h0A);
    host_wr(8'h0A);
    check(pwr_act == 1'b1, "R9", pwr_act, 1);
    wake_ie = 1'b0;
    host_wr(8'h08);
    check(pwr_act == 1'b0, "R8", pwr_act, 0);

    // R10 lead counter
    check(rd_data[6] == 1'b0, "R10", rd_data[6], 0);
    upd_pend = 1'b1; idle(1); upd_pend = 1'b0;
    check(rd_data[6] == 1'b1, "R10", rd_data[6], 1);
    for (int t = 1; t <= 4; t++) begin
      if (t == 2) begin
        upd_done = 1'b1; idle(1); upd_done = 1'b0;
        check(rd_data[6] == 1'b1, "R10", rd_data[6], 1);
      end
      one_tick();
      check(upd_go == (t == 4), "R10", upd_go, t == 4);
    end
    idle(1);
    check(upd_go == 1'b0, "R10", upd_go, 0);
    check(rd_data[6] == 1'b1, "R10", rd_data[6], 1);
    upd_done = 1'b1; idle(1); upd_done = 1'b0;
    check(rd_data[6] == 1'b0, "R10", rd_data[6], 0);
    one_tick();
    check(upd_go == 1'b0, "R10", upd_go, 0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule